// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host hands over one word at a time on a valid/ready port: a 17-bit address, a write flag and, for stores, a byte of data. The controller turns each request into a pin sequence on the memory side. Loads return their byte on a one-clock response strobe.

The memory side has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. Data uses three signals: an outbound byte, an inbound byte and a drive enable for an external tristate pad. Every timing window is a whole number of clocks. Each count is derived from the clock period and a nanosecond limit, all of which are parameters.

Between operations the memory is held in standby. The sequencer inserts a bus-turnaround interval after every load. This keeps the controller from driving the data pins while the memory may still be driving them. Stores are strobed by the write-enable line, and address and data stay stable across its rising edge.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request pending: mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1, mem_dout_en=0, req_ready=1, rsp_valid=0.
- R2: A load holds mem_sel_n=0, mem_sel=1 and mem_wr_n=1, and drives mem_rd_n low for exactly N_RD consecutive cycles with mem_addr equal to the request address. N_RD is the larger of the cycle counts for the address access time and the output-enable access time. Each count is ceil(t/period), with a minimum of 1.
- R3: The load byte is sampled from mem_din in the last of the N_RD enable-low cycles. It appears on rsp_rdata with rsp_valid high for exactly one clock, in the cycle after that sample.
- R4: A store drives mem_wr_n low for N_WLOW consecutive cycles, with both selects active, mem_dout_en=1, mem_dout equal to the request data and mem_addr equal to the request address. N_WLOW is the largest of the cycle counts for the write-pulse width, the data-setup time and (write cycle time minus one cycle), with a minimum of 1.
- R5: In the cycle in which mem_wr_n returns high, the selects, address, data and mem_dout_en are unchanged. In the following cycle both selects return to standby and mem_dout_en falls.
- R6: mem_wr_n and mem_rd_n are never low together, and mem_dout_en is never high while mem_rd_n is low.
- R7: After a load, the selects are in standby and mem_rd_n is high for N_HZ cycles before req_ready returns. mem_dout_en never rises within N_HZ cycles of mem_rd_n rising. N_HZ is the cycle count for the output turn-off time.
- R8: req_ready falls in the cycle after a request is accepted. It stays low for exactly N_RD+N_HZ cycles for a load and N_WLOW+1 cycles for a store.
- R9: A store followed by a load to the same address returns the stored byte, for any address, including 0 and 17'h1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Word address of the request |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Load data valid, one clock |
| rsp_rdata | output | 8 | Load data |
| mem_addr | output | 17 | Address to the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Data toward the pad |
| mem_din | input | 8 | Data from the pad |
| mem_dout_en | output | 1 | Pad drive enable |

## Verification
The hardest situation to reach is a load sampled too early. With the default 20 ns period, every window collapses to a single cycle, so an off-by-one in the access count does not show at the ports. The bench therefore declares a 4 ns period to the design. This stretches the windows to three load cycles, two store cycles and two turnaround cycles. The bench memory model returns a poison byte until the output enable has been low for the full load window. It sweeps stores and loads over many addresses and both address extremes, interleaving them so that load-to-store turnaround occurs on every pair.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_REC,
        PH_WR_LOW,
        PH_WR_HOLD
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic rd_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_STANDBY = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1,
                                       rd_n: 1'b1, drive: 1'b0};

    function automatic int cyc_ceil(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_async_pkg::*;
(
    input  phase_e ph,
    output pins_t  pins
);
    always_comb begin
        pins = PINS_STANDBY;
        case (ph)
            PH_RD_ACC: begin
                pins.sel_n = 1'b0;
                pins.sel   = 1'b1;
                pins.rd_n  = 1'b0;
            end
            PH_WR_LOW: begin
                pins.sel_n = 1'b0;
                pins.sel   = 1'b1;
                pins.wr_n  = 1'b0;
                pins.drive = 1'b1;
            end
            PH_WR_HOLD: begin
                pins.sel_n = 1'b0;
                pins.sel   = 1'b1;
                pins.drive = 1'b1;
            end
            default: pins = PINS_STANDBY;
        endcase
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_async_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ACC_NS      = 10,
    parameter int T_OEACC_NS    = 5,
    parameter int T_WPULSE_NS   = 7,
    parameter int T_WCYC_NS     = 10,
    parameter int T_DSETUP_NS   = 5,
    parameter int T_HIZ_NS      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dout_en
);
    // Window lengths in clocks
    localparam int N_RD   = imax(cyc_ceil(T_ACC_NS, CLK_PERIOD_NS),
                                 cyc_ceil(T_OEACC_NS, CLK_PERIOD_NS));
    localparam int N_WCM1 = cyc_ceil(T_WCYC_NS, CLK_PERIOD_NS) - 1;
    localparam int N_WLOW = imax(imax(cyc_ceil(T_WPULSE_NS, CLK_PERIOD_NS),
                                      cyc_ceil(T_DSETUP_NS, CLK_PERIOD_NS)),
                                 imax(N_WCM1, 1));
    localparam int N_HZ   = cyc_ceil(T_HIZ_NS, CLK_PERIOD_NS);
    localparam int N_MAX  = imax(imax(N_RD, N_WLOW), N_HZ);
    localparam int CNT_W  = imax($clog2(N_MAX + 1), 1);

    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_WLOW = CNT_W'(N_WLOW - 1);
    localparam logic [CNT_W-1:0] LD_HZ   = CNT_W'(N_HZ - 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } regs_t;

    regs_t            r_d, r_q;
    pins_t            pins_d, pins_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_pin_decode u_decode (
        .ph   (r_d.ph),
        .pins (pins_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.ph  = PH_WR_LOW;
                        tmr_val = LD_WLOW;
                    end else begin
                        r_d.ph  = PH_RD_ACC;
                        tmr_val = LD_RD;
                    end
                end
            end
            PH_RD_ACC: begin
                if (tmr_done) begin
                    r_d.rdata  = mem_din;
                    r_d.rvalid = 1'b1;
                    r_d.ph     = PH_RD_REC;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_HZ;
                end
            end
            PH_RD_REC: begin
                if (tmr_done) r_d.ph = PH_IDLE;
            end
            PH_WR_LOW: begin
                if (tmr_done) r_d.ph = PH_WR_HOLD;
            end
            PH_WR_HOLD: r_d.ph = PH_IDLE;
            default:    r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '{ph: PH_IDLE, addr: '0, wdata: '0, rdata: '0, rvalid: 1'b0};
            pins_q <= PINS_STANDBY;
        end else begin
            r_q    <= r_d;
            pins_q <= pins_d;
        end
    end

    assign req_ready   = (r_q.ph == PH_IDLE);
    assign rsp_valid   = r_q.rvalid;
    assign rsp_rdata   = r_q.rdata;
    assign mem_addr    = r_q.addr;
    assign mem_dout    = r_q.wdata;
    assign mem_sel_n   = pins_q.sel_n;
    assign mem_sel     = pins_q.sel;
    assign mem_wr_n    = pins_q.wr_n;
    assign mem_rd_n    = pins_q.rd_n;
    assign mem_dout_en = pins_q.drive;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_async_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_HIZ_NS      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_dout_en
);
    localparam int HZ = cyc_ceil(T_HIZ_NS, CLK_PERIOD_NS);

    // Clocks seen with the output enable high, saturating
    int hz_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hz_cnt <= HZ;
        else if (!mem_rd_n) hz_cnt <= 0;
        else if (hz_cnt < HZ + 1) hz_cnt <= hz_cnt + 1;
    end

    // R6
    a_r6_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wr_n && !mem_rd_n));
    // R6
    a_r6_no_drive_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_rd_n));
    // R3
    a_r3_resp_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R1
    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && !mem_dout_en && mem_wr_n && mem_rd_n));
    // R5
    a_r5_hold_at_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_dout_en && mem_sel && !mem_sel_n && $stable(mem_addr)));
    // R7
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (hz_cnt >= HZ));
    // R8
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_HIZ_NS      (T_HIZ_NS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_addr    (mem_addr),
    .mem_sel_n   (mem_sel_n),
    .mem_sel     (mem_sel),
    .mem_wr_n    (mem_wr_n),
    .mem_rd_n    (mem_rd_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
    localparam int CLKNS = 4;   // period declared to the design
    function automatic int cdiv(input int t);
        int c;
        c = (t + CLKNS - 1) / CLKNS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_RD   = (cdiv(10) > cdiv(5)) ? cdiv(10) : cdiv(5);
    localparam int E_HZ   = cdiv(5);
    localparam int E_WLOW = (cdiv(7) > cdiv(10) - 1) ? cdiv(7) : cdiv(10) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dout_en;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int contention = 0;

    always #10 clk = ~clk;   // 50 MHz

    sram_async_ctrl #(.CLK_PERIOD_NS(CLKNS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    // Memory model indexed by low address byte; poison until access window met
    logic [7:0] mem [256];
    int   oe_run = 0;
    logic prev_wr_n = 1'b1;
    wire  selected = !mem_sel_n && mem_sel;

    always_comb begin
        if (selected && !mem_rd_n && mem_wr_n && oe_run >= E_RD)
            mem_din = mem[mem_addr[7:0]];
        else
            mem_din = 8'hEE;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (selected && !mem_rd_n && mem_wr_n) oe_run = oe_run + 1;
        else oe_run = 0;
        if (!prev_wr_n && mem_wr_n && selected && mem_dout_en)
            mem[mem_addr[7:0]] = mem_dout;
        prev_wr_n = mem_wr_n;
        if ((!mem_wr_n && !mem_rd_n) || (mem_dout_en && !mem_rd_n))
            contention = contention + 1;
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic txn(input logic wr, input logic [16:0] a, input logic [7:0] d,
                       input logic [7:0] exp);
        int busy;
        int n_oe;
        int n_we;
        int n_hold;
        int n_rv;
        int bad_addr;
        int bad_data;
        int last_oe;
        int first_rv;
        int got;
        busy = 0; n_oe = 0; n_we = 0; n_hold = 0; n_rv = 0;
        bad_addr = 0; bad_data = 0; last_oe = -1; first_rv = -1; got = -1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 50) begin
            busy = busy + 1;
            if (selected && mem_addr != a) bad_addr = bad_addr + 1;
            if (!mem_rd_n) begin
                n_oe = n_oe + 1;
                last_oe = busy;
                if (!(selected && mem_wr_n)) bad_addr = bad_addr + 1;
            end
            if (!mem_wr_n) begin
                n_we = n_we + 1;
                if (!(selected && mem_dout_en && mem_dout == d)) bad_data = bad_data + 1;
            end
            if (mem_wr_n && selected && mem_dout_en) begin
                n_hold = n_hold + 1;
                if (mem_dout != d) bad_data = bad_data + 1;
            end
            if (rsp_valid) begin
                n_rv = n_rv + 1;
                if (first_rv < 0) first_rv = busy;
                got = rsp_rdata;
            end
            @(negedge clk);
        end
        if (wr) begin
            check("R8 store busy length", busy == E_WLOW + 1, busy, E_WLOW + 1);
            check("R4 strobe low width", n_we == E_WLOW, n_we, E_WLOW);
            check("R4 address/data during strobe", bad_addr == 0 && bad_data == 0,
                  bad_addr + bad_data, 0);
            check("R5 hold cycle", n_hold == 1, n_hold, 1);
        end else begin
            check("R8 load busy length", busy == E_RD + E_HZ, busy, E_RD + E_HZ);
            check("R2 output enable width", n_oe == E_RD, n_oe, E_RD);
            check("R2 address during load", bad_addr == 0, bad_addr, 0);
            check("R3 response strobe count", n_rv == 1, n_rv, 1);
            check("R3 response timing", first_rv == E_RD + 1, first_rv, E_RD + 1);
            check("R7 turnaround length", busy - last_oe == E_HZ, busy - last_oe, E_HZ);
            check("R9 load data", got == int'(exp), got, exp);
        end
        check("R1 standby when ready", mem_sel_n && !mem_sel && !mem_dout_en && !rsp_valid,
              mem_sel, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset pins", mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dout_en,
              {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dout_en}, 5'b10110);
        check("R1 reset handshake", req_ready && !rsp_valid, req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", req_ready && mem_sel_n && !mem_sel && !mem_dout_en,
              req_ready, 1);
        // R9 extremes
        txn(1'b1, 17'h1FFFF, 8'hA5, 8'h00);
        txn(1'b0, 17'h1FFFF, 8'h00, 8'hA5);
        // Sweep stores then loads
        for (int i = 0; i < 32; i++)
            txn(1'b1, 17'((i * 4099) & 17'h1FFFF), 8'((i * 37 + 5) & 8'hFF), 8'h00);
        for (int i = 0; i < 32; i++)
            txn(1'b0, 17'((i * 4099) & 17'h1FFFF), 8'h00, 8'((i * 37 + 5) & 8'hFF));
        // Interleaved load->store turnaround on every pair (R7)
        for (int i = 0; i < 16; i++) begin
            txn(1'b0, 17'((i * 4099) & 17'h1FFFF), 8'h00, 8'((i * 37 + 5) & 8'hFF));
            txn(1'b1, 17'((i * 4099) & 17'h1FFFF), 8'((i * 11 + 200) & 8'hFF), 8'h00);
            txn(1'b0, 17'((i * 4099) & 17'h1FFFF), 8'h00, 8'((i * 11 + 200) & 8'hFF));
        end
        check("R6 no strobe or drive overlap", contention == 0, contention, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule